// File: doc/BRIEF.md
# Startup and Keep-Alive Bias Sequencer

This block is the digital sequencer behind a controller's high-voltage startup switch. It reads three supply-threshold comparator flags: supply above the turn-on level (about 12.7 V), above the keep-alive low level (about 10 V) and above the turn-off level (about 8 V). It also reads a gate-drive-active indication and a standby command. From these it drives the startup-switch enable, the reference-rail enable, the controller-enable flag and a permit for the soft-start and switching logic.

At power-up the startup switch charges the bias capacitor until the supply crosses the turn-on level. The switch then opens and the controller comes alive. While the gate drive is idle in standby, the same switch acts as a hysteretic keep-alive regulator between the keep-alive and turn-on levels. Whenever pulses are active the switch is held off. If the supply sags below the turn-off level at any point after enabling, the block falls back to startup charging and waits for the turn-on level again.

Each comparator flag is synchronized through two flip-flops. It is then filtered so that only a level held for a programmable number of cycles is acted upon.

Top module: `bias_sequencer`

## Requirements
- R1: While reset is high and after it, until the turn-on flag is accepted, the state is STARTUP_CHARGE, the startup switch is on, and the reference, controller-enable and permit outputs are low. The turn-off and keep-alive flags alone do not enable anything.
- R2: When the turn-on flag is accepted in STARTUP_CHARGE, the machine enters RUN, or STANDBY_IDLE if standby is requested. The startup switch turns off and the reference and controller enables go high.
- R3: In standby with the gate drive idle, an accepted low keep-alive flag moves STANDBY_IDLE to STANDBY_CHARGE with the switch on. An accepted high turn-on flag moves it back to STANDBY_IDLE with the switch off.
- R4: Whenever gate drive is active, the startup switch enable is low in the same cycle. In STANDBY_CHARGE, active gate drive also returns the machine to STANDBY_IDLE on the next edge.
- R5: An accepted low turn-off flag in any enabled state returns the machine to STARTUP_CHARGE. This drops the reference and controller enables and turns the switch on.
- R6: Releasing standby in STANDBY_IDLE or STANDBY_CHARGE with the turn-off flag high enters RUN on the next edge, with no startup sequence.
- R7: After a fall back to STARTUP_CHARGE, the machine stays there even with the turn-off and keep-alive flags high, until the turn-on flag is accepted again (retry).
- R8: A comparator flag change takes effect only if it persists. A change held for STABLE_CYCLES cycles at the synchronizer output is accepted 2+STABLE_CYCLES edges after the input changes, and the state moves on the next edge. A change shorter than STABLE_CYCLES cycles is ignored.
- R9: The switching permit is high only in RUN with standby deasserted and the accepted turn-off flag high. It drops in the same cycle that standby is raised.
- R10: The status output encodes STARTUP_CHARGE=0, RUN=1, STANDBY_IDLE=2, STANDBY_CHARGE=3.
- R11: Raising standby in RUN with the turn-off flag high enters STANDBY_IDLE on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_above_on | input | 1 | Comparator: supply above turn-on level |
| vdd_above_keep | input | 1 | Comparator: supply above keep-alive low level |
| vdd_above_off | input | 1 | Comparator: supply above turn-off level |
| gate_active | input | 1 | Gate-drive pulses present |
| standby_req | input | 1 | Standby command, high = standby |
| startup_sw_en | output | 1 | High-voltage startup switch enable |
| ref_en | output | 1 | Reference rail enable |
| ctrl_en | output | 1 | Controller enable / supply-OK |
| switch_permit | output | 1 | Permit for soft-start and switching |
| state_o | output | 2 | Current sequencer state code |

## Verification
A comparator flag change reaches the state register on the (STABLE_CYCLES+3)-th rising edge after it is driven: two edges in the synchronizer, STABLE_CYCLES edges in the filter and one in the state register. Gate-active and standby go straight to the state logic. They move the state one edge later, while the switch enable and the permit react in the same cycle. The bench drives inputs just after a rising edge and compares every output to a behavioural model at each falling edge. Scenario checks wait exactly the latency above, for example one edge short and then on the edge, or a fixed margin past it.

// File: rtl/bias_seq_pkg.sv
package bias_seq_pkg;

    typedef enum logic [1:0] {
        ST_STARTUP     = 2'd0,
        ST_RUN         = 2'd1,
        ST_STBY_IDLE   = 2'd2,
        ST_STBY_CHARGE = 2'd3
    } bias_state_e;

    localparam int FLAG_COUNT = 3;
    localparam int IDX_ON     = 0;
    localparam int IDX_KEEP   = 1;
    localparam int IDX_OFF    = 2;

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d.s1 = raw_i;
        d.s2 = q.s1;
        if (rst) begin
            d = '0;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign sync_o = q.s2;

endmodule

// File: rtl/flag_filter.sv
module flag_filter #(
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    output logic level_o
);

    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          level;
    } filt_t;

    filt_t d, q;

    always_comb begin
        d = q;
        if (sync_i == q.level) begin
            d.cnt = '0;
        end else if (q.cnt == LAST) begin
            d.cnt   = '0;
            d.level = sync_i;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
        if (rst) begin
            d = '0;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign level_o = q.level;

endmodule

// File: rtl/bias_fsm.sv
module bias_fsm
    import bias_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        on_ok,
    input  logic        keep_ok,
    input  logic        off_ok,
    input  logic        gate_active,
    input  logic        standby_req,
    output logic        startup_sw_en,
    output logic        ref_en,
    output logic        ctrl_en,
    output logic        switch_permit,
    output bias_state_e state_o
);

    typedef struct packed {
        bias_state_e st;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_STARTUP: begin
                if (on_ok) begin
                    d.st = standby_req ? ST_STBY_IDLE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (!off_ok) begin
                    d.st = ST_STARTUP;
                end else if (standby_req) begin
                    d.st = ST_STBY_IDLE;
                end
            end
            ST_STBY_IDLE: begin
                if (!off_ok) begin
                    d.st = ST_STARTUP;
                end else if (!standby_req) begin
                    d.st = ST_RUN;
                end else if (!keep_ok && !gate_active) begin
                    d.st = ST_STBY_CHARGE;
                end
            end
            ST_STBY_CHARGE: begin
                if (!off_ok) begin
                    d.st = ST_STARTUP;
                end else if (!standby_req) begin
                    d.st = ST_RUN;
                end else if (on_ok || gate_active) begin
                    d.st = ST_STBY_IDLE;
                end
            end
            default: d.st = ST_STARTUP;
        endcase
        if (rst) begin
            d.st = ST_STARTUP;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    logic charging;
    assign charging      = (q.st == ST_STARTUP) || (q.st == ST_STBY_CHARGE);
    assign startup_sw_en = charging && !gate_active;
    assign ref_en        = (q.st != ST_STARTUP);
    assign ctrl_en       = (q.st != ST_STARTUP);
    assign switch_permit = (q.st == ST_RUN) && !standby_req && off_ok;
    assign state_o       = q.st;

endmodule

// File: rtl/bias_sequencer.sv
module bias_sequencer
    import bias_seq_pkg::*;
#(
    parameter int STABLE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vdd_above_on,
    input  logic       vdd_above_keep,
    input  logic       vdd_above_off,
    input  logic       gate_active,
    input  logic       standby_req,
    output logic       startup_sw_en,
    output logic       ref_en,
    output logic       ctrl_en,
    output logic       switch_permit,
    output logic [1:0] state_o
);

    logic [FLAG_COUNT-1:0] raw_flags;
    logic [FLAG_COUNT-1:0] sync_flags;
    logic [FLAG_COUNT-1:0] ok_flags;
    bias_state_e           st;

    assign raw_flags[IDX_ON]   = vdd_above_on;
    assign raw_flags[IDX_KEEP] = vdd_above_keep;
    assign raw_flags[IDX_OFF]  = vdd_above_off;

    flag_sync #(.WIDTH(FLAG_COUNT)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw_flags),
        .sync_o (sync_flags)
    );

    for (genvar g = 0; g < FLAG_COUNT; g++) begin : g_filt
        flag_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filt (
            .clk     (clk),
            .rst     (rst),
            .sync_i  (sync_flags[g]),
            .level_o (ok_flags[g])
        );
    end

    bias_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .on_ok         (ok_flags[IDX_ON]),
        .keep_ok       (ok_flags[IDX_KEEP]),
        .off_ok        (ok_flags[IDX_OFF]),
        .gate_active   (gate_active),
        .standby_req   (standby_req),
        .startup_sw_en (startup_sw_en),
        .ref_en        (ref_en),
        .ctrl_en       (ctrl_en),
        .switch_permit (switch_permit),
        .state_o       (st)
    );

    assign state_o = st;

endmodule

// File: rtl/bias_seq_chk.sv
module bias_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       gate_active,
    input logic       standby_req,
    input logic       startup_sw_en,
    input logic       ref_en,
    input logic       ctrl_en,
    input logic       switch_permit,
    input logic [1:0] state_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state_o == 2'd0 && !ref_en && !ctrl_en && !switch_permit));

    // R4
    gate_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
        gate_active |-> !startup_sw_en);

    // R9
    permit_gated_chk: assert property (@(posedge clk) disable iff (rst)
        switch_permit |-> (ref_en && !standby_req && state_o == 2'd1));

    // R11
    run_to_standby_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd1 && standby_req) |=> (state_o != 2'd1));

    // R6
    leave_charge_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3 && !standby_req) |=> (state_o != 2'd3));

    // R5
    startup_rail_off_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0) |-> (!ref_en && !ctrl_en));

endmodule

bind bias_sequencer bias_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .gate_active   (gate_active),
    .standby_req   (standby_req),
    .startup_sw_en (startup_sw_en),
    .ref_en        (ref_en),
    .ctrl_en       (ctrl_en),
    .switch_permit (switch_permit),
    .state_o       (state_o)
);

// File: tb/tb_bias_sequencer.sv
`timescale 1ns/1ps
module tb_bias_sequencer;

    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic v_on = 1'b0, v_keep = 1'b0, v_off = 1'b0;
    logic gate = 1'b0, stby = 1'b0;
    logic sw, refe, ctl, permit;
    logic [1:0] st;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bias_sequencer #(.STABLE_CYCLES(N)) dut (
        .clk(clk), .rst(rst),
        .vdd_above_on(v_on), .vdd_above_keep(v_keep), .vdd_above_off(v_off),
        .gate_active(gate), .standby_req(stby),
        .startup_sw_en(sw), .ref_en(refe), .ctrl_en(ctl),
        .switch_permit(permit), .state_o(st)
    );

    // behavioural reference model
    bit pipe [3][$];
    bit acc [3];
    int run_len [3];
    int ms = 0;

    function automatic bit raw_of(int i);
        return (i == 0) ? v_on : (i == 1) ? v_keep : v_off;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ms = 0;
            for (int i = 0; i < 3; i++) begin
                pipe[i] = '{0, 0};
                acc[i] = 0;
                run_len[i] = 0;
            end
        end else begin
            int nx;
            nx = ms;
            if (ms == 0) begin
                if (acc[0]) nx = stby ? 2 : 1;
            end else if (!acc[2]) begin
                nx = 0;
            end else if (ms == 1) begin
                if (stby) nx = 2;
            end else if (!stby) begin
                nx = 1;
            end else if (ms == 2) begin
                if (!acc[1] && !gate) nx = 3;
            end else begin
                if (acc[0] || gate) nx = 2;
            end
            ms = nx;
            for (int i = 0; i < 3; i++) begin
                bit s2;
                s2 = pipe[i][0];
                if (s2 != acc[i]) begin
                    run_len[i]++;
                    if (run_len[i] == N) begin
                        acc[i] = s2;
                        run_len[i] = 0;
                    end
                end else begin
                    run_len[i] = 0;
                end
                void'(pipe[i].pop_front());
                pipe[i].push_back(raw_of(i));
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check("R10 state", int'(st), ms);
            check("R4 switch", int'(sw), int'((ms == 0 || ms == 3) && !gate));
            check("R2 ref", int'(refe), int'(ms != 0));
            check("R5 ctrl", int'(ctl), int'(ms != 0));
            check("R9 permit", int'(permit), int'(ms == 1 && !stby && acc[2]));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1 (finish)");
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        check("R1 reset state", int'(st), 0);
        check("R1 reset switch", int'(sw), 1);
        check("R1 reset ref", int'(refe), 0);
        rst = 1'b0;
        v_off = 1; v_keep = 1;
        cyc(10);
        check("R1 no enable below on", int'(st), 0);
        check("R1 ctrl low", int'(ctl), 0);
        v_on = 1;
        cyc(N + 2);
        check("R8 not yet accepted", int'(st), 0);
        cyc(1);
        check("R8 accepted on edge", int'(st), 1);
        check("R2 switch off", int'(sw), 0);
        check("R2 ref on", int'(refe), 1);
        gate = 1;
        cyc(1);
        check("R9 permit in RUN", int'(permit), 1);
        v_off = 0;
        cyc(N - 1);
        v_off = 1;
        cyc(10);
        check("R8 glitch ignored", int'(st), 1);
        stby = 1;
        #1;
        check("R9 permit drops at once", int'(permit), 0);
        cyc(1);
        check("R11 standby entry", int'(st), 2);
        gate = 0;
        v_on = 0; v_keep = 0;
        cyc(10);
        check("R3 keep-alive charge", int'(st), 3);
        check("R3 switch on", int'(sw), 1);
        gate = 1;
        #1;
        check("R4 gate forces off", int'(sw), 0);
        cyc(1);
        check("R4 charge abandoned", int'(st), 2);
        gate = 0;
        cyc(1);
        check("R3 charge resumes", int'(st), 3);
        v_keep = 1; v_on = 1;
        cyc(10);
        check("R3 charge ends at on", int'(st), 2);
        check("R3 switch off", int'(sw), 0);
        stby = 0;
        cyc(1);
        check("R6 direct to RUN", int'(st), 1);
        check("R6 permit", int'(permit), 1);
        v_on = 0; v_keep = 0; v_off = 0;
        cyc(10);
        check("R5 fall back", int'(st), 0);
        check("R5 ref off", int'(refe), 0);
        check("R5 switch on", int'(sw), 1);
        v_off = 1; v_keep = 1;
        cyc(10);
        check("R7 waits for on", int'(st), 0);
        v_on = 1;
        cyc(10);
        check("R7 restart", int'(st), 1);
        v_on = 0; v_keep = 0; v_off = 0;
        cyc(10);
        check("R7 retry to startup", int'(st), 0);
        v_off = 1; v_keep = 1;
        cyc(10);
        check("R7 still charging", int'(st), 0);
        stby = 1; v_on = 1;
        cyc(10);
        check("R2 enable into standby", int'(st), 2);
        check("R2 ref on in standby", int'(refe), 1);
        cyc(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule